// File: doc/BRIEF.md
# Late-write flow-through synchronous SRAM

This block is a synthesizable behavioural model of a synchronous static RAM. Each word is split into byte lanes. Reads are flow-through: the word addressed by a read command appears on the read-data port during the cycle after the command is accepted. Writes are late: the address and lane enables are registered with the command, and the data word is taken one accepted clock edge later. Because write data arrives in the same slot that read data leaves, reads and writes can follow each other in any order without an idle cycle.

Write data is captured first into a pending stage and is committed to the array on the next accepted edge. A read of an address that still has a pending write returns the pending lanes merged over the array contents. Bursts of four are continued by an advance input that steps an internal 2-bit counter in either interleaved or linear order. A hold input freezes every register. The tri-state data bus is replaced by a separate read-data port and a drive flag that is gated combinationally by an output enable.

Top module: `lwsram`

## Requirements
- R1: A read command is accepted on a rising edge with hold low, advance low, wr_n high and all three chip enables active. In the cycle after that edge, rdata holds the word at that address and rvalid is 1 while oe_n is low.
- R2: A write command (wr_n low, otherwise accepted as in R1) registers the address and lane enables on its edge. The word on wdata is taken at the next accepted edge.
- R3: Reads and writes may be issued on consecutive edges in any order. A read of an address whose write data was taken on the same edge returns that new data.
- R4: be_n is active low. Bit 0 gates rdata/wdata bits 8:0 and bit 1 gates bits 17:9. Disabled lanes keep their old contents, and this also holds in the merged word returned for a pending write.
- R5: With adv high on an accepted edge, addr, the chip enables and wr_n are ignored. The operation type of the running burst continues, so a write burst takes one data word at the edge after each advance. be_n is sampled on every accepted edge.
- R6: The burst order is latched from ord_lin at the burst's first command. When 0, the two low address bits are start XOR count. When 1, they are start plus count modulo 4. The upper address bits stay fixed.
- R7: With hold high, the clock edge has no effect. The command registers, the burst counter and any pending write stay frozen, rdata holds its value, and write data is taken at the next edge with hold low.
- R8: A non-advance accepted edge with en0_n high, en1 low or en2_n high deselects the device. rvalid stays 0, no write happens, and advances issued while deselected keep it deselected.
- R9: oe_n acts combinationally. While it is high, rvalid is 0 and rdata is 0. rdata is 0 whenever rvalid is 0.
- R10: After reset the device is deselected with no pending write, and rvalid is 0. Array contents are not reset.
- R11: In the cycle after an accepted write command or write advance, rvalid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hold | input | 1 | 1 = ignore this clock edge and freeze all state |
| en0_n | input | 1 | Chip enable, active low |
| en1 | input | 1 | Chip enable, active high |
| en2_n | input | 1 | Chip enable, active low |
| wr_n | input | 1 | 0 = write command, 1 = read command |
| be_n | input | LANES | Per-lane write enables, active low |
| adv | input | 1 | 1 = continue the burst at the next counter address |
| ord_lin | input | 1 | Burst order: 0 interleaved, 1 linear |
| addr | input | log2(DEPTH) | Word address (DEPTH a power of two, at least 8) |
| wdata | input | LANES*LANE_W | Write data, taken one accepted edge after its command |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| rdata | output | LANES*LANE_W | Read data, zero when not driving |
| rvalid | output | 1 | Stands in for the output drivers being on |

## Verification
Read data is due in the cycle after the edge that accepts the read command, so the bench drives each command on a falling edge and samples rdata on the next falling edge. Write data is driven in the cycle after its command, so that it is taken on the following accepted edge. An immediate read of the same address is checked in that same sampled cycle, which exercises the forwarding path. Each cycle of hold pushes every one of these deadlines back by one cycle, and the bench accounts for this. Changes on oe_n are checked 1 ns after they are applied, with no clock edge in between.

// File: rtl/lwsram_pkg.sv
package lwsram_pkg;
  localparam int unsigned BURST_W = 2;

  typedef enum logic {
    ORD_INTERLEAVE = 1'b0,
    ORD_LINEAR     = 1'b1
  } burst_ord_e;

  // Low address bits for burst position cnt from start
  function automatic logic [BURST_W-1:0] burst_low(
    input logic [BURST_W-1:0] start,
    input logic [BURST_W-1:0] cnt,
    input burst_ord_e         ord
  );
    if (ord == ORD_LINEAR) return start + cnt;
    else                   return start ^ cnt;
  endfunction
endpackage

// File: rtl/lwsram_rstsync.sv
module lwsram_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  assign sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sn = sh_q[STAGES-1];
endmodule

// File: rtl/lwsram_cmd.sv
module lwsram_cmd
  import lwsram_pkg::*;
#(
  parameter int AW    = 6,
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             en0_n,
  input  logic             en1,
  input  logic             en2_n,
  input  logic             wr_n,
  input  logic [LANES-1:0] be_n,
  input  logic             adv,
  input  logic             ord_lin,
  input  logic [AW-1:0]    addr,
  output logic             act_q,
  output logic             wr_q,
  output logic [LANES-1:0] be_q,
  output logic [AW-1:0]    addr_q
);
  logic               act_d, wr_d;
  logic [LANES-1:0]   be_d;
  logic [AW-1:0]      addr_d;
  logic [BURST_W-1:0] start_q, start_d;
  logic [BURST_W-1:0] cnt_q, cnt_d, cnt_nx;
  burst_ord_e         ord_q, ord_d;

  assign cnt_nx = cnt_q + 1'b1;

  always_comb begin
    act_d   = act_q;
    wr_d    = wr_q;
    be_d    = be_q;
    addr_d  = addr_q;
    start_d = start_q;
    cnt_d   = cnt_q;
    ord_d   = ord_q;
    if (!hold) begin
      be_d = ~be_n;
      if (adv) begin
        cnt_d  = cnt_nx;
        addr_d = {addr_q[AW-1:BURST_W], burst_low(start_q, cnt_nx, ord_q)};
      end else begin
        act_d   = !en0_n && en1 && !en2_n;
        wr_d    = !wr_n;
        addr_d  = addr;
        start_d = addr[BURST_W-1:0];
        cnt_d   = '0;
        ord_d   = burst_ord_e'(ord_lin);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      wr_q    <= 1'b0;
      be_q    <= '0;
      addr_q  <= '0;
      start_q <= '0;
      cnt_q   <= '0;
      ord_q   <= ORD_INTERLEAVE;
    end else begin
      act_q   <= act_d;
      wr_q    <= wr_d;
      be_q    <= be_d;
      addr_q  <= addr_d;
      start_q <= start_d;
      cnt_q   <= cnt_d;
      ord_q   <= ord_d;
    end
  end
endmodule

// File: rtl/lwsram_store.sv
module lwsram_store #(
  parameter int DEPTH  = 64,
  parameter int AW     = 6,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    hold,
  input  logic                    act,
  input  logic                    wr,
  input  logic [LANES-1:0]        be,
  input  logic [AW-1:0]           addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    oe_n,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rvalid
);
  localparam int DW = LANES * LANE_W;

  logic             pv_q, pv_d;
  logic [AW-1:0]    pa_q, pa_d;
  logic [LANES-1:0] pbe_q, pbe_d;
  logic [DW-1:0]    pd_q, pd_d;
  logic             commit;
  logic [DW-1:0]    word;

  always_comb begin
    pv_d  = pv_q;
    pa_d  = pa_q;
    pbe_d = pbe_q;
    pd_d  = pd_q;
    if (!hold) begin
      pv_d  = act && wr;
      pa_d  = addr;
      pbe_d = be;
      pd_d  = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv_q  <= 1'b0;
      pa_q  <= '0;
      pbe_q <= '0;
      pd_q  <= '0;
    end else begin
      pv_q  <= pv_d;
      pa_q  <= pa_d;
      pbe_q <= pbe_d;
      pd_q  <= pd_d;
    end
  end

  assign commit = pv_q && !hold;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic              fwd;

    always_ff @(posedge clk) begin
      if (commit && pbe_q[l]) mem[pa_q] <= pd_q[l*LANE_W +: LANE_W];
    end

    assign fwd = pv_q && pbe_q[l] && (pa_q == addr);
    assign word[l*LANE_W +: LANE_W] = fwd ? pd_q[l*LANE_W +: LANE_W] : mem[addr];
  end

  assign rvalid = act && !wr && !oe_n;
  assign rdata  = rvalid ? word : '0;
endmodule

// File: rtl/lwsram.sv
module lwsram #(
  parameter int DEPTH  = 64,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      hold,
  input  logic                      en0_n,
  input  logic                      en1,
  input  logic                      en2_n,
  input  logic                      wr_n,
  input  logic [LANES-1:0]          be_n,
  input  logic                      adv,
  input  logic                      ord_lin,
  input  logic [$clog2(DEPTH)-1:0]  addr,
  input  logic [LANES*LANE_W-1:0]   wdata,
  input  logic                      oe_n,
  output logic [LANES*LANE_W-1:0]   rdata,
  output logic                      rvalid
);
  localparam int AW     = $clog2(DEPTH);
  localparam int WORD_W = LANES * LANE_W;

  logic             rst_sn;
  logic             act_q, wr_q;
  logic [LANES-1:0] be_q;
  logic [AW-1:0]    addr_q;

  lwsram_rstsync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  lwsram_cmd #(.AW(AW), .LANES(LANES)) u_cmd (
    .clk     (clk),
    .rst_n   (rst_sn),
    .hold    (hold),
    .en0_n   (en0_n),
    .en1     (en1),
    .en2_n   (en2_n),
    .wr_n    (wr_n),
    .be_n    (be_n),
    .adv     (adv),
    .ord_lin (ord_lin),
    .addr    (addr),
    .act_q   (act_q),
    .wr_q    (wr_q),
    .be_q    (be_q),
    .addr_q  (addr_q)
  );

  lwsram_store #(.DEPTH(DEPTH), .AW(AW), .LANE_W(LANE_W), .LANES(LANES)) u_store (
    .clk    (clk),
    .rst_n  (rst_sn),
    .hold   (hold),
    .act    (act_q),
    .wr     (wr_q),
    .be     (be_q),
    .addr   (addr_q),
    .wdata  (wdata),
    .oe_n   (oe_n),
    .rdata  (rdata),
    .rvalid (rvalid)
  );
endmodule

// File: rtl/lwsram_chk.sv
module lwsram_chk #(
  parameter int DW = 18
) (
  input logic          clk,
  input logic          rst_sn,
  input logic          hold,
  input logic          en0_n,
  input logic          en1,
  input logic          en2_n,
  input logic          wr_n,
  input logic          adv,
  input logic          oe_n,
  input logic [DW-1:0] rdata,
  input logic          rvalid
);
  logic cmd_ok, sel_ok;
  assign cmd_ok = !hold && !adv;
  assign sel_ok = !en0_n && en1 && !en2_n;

  // R9: output enable high silences the outputs
  a_r9_oe_quiet: assert property (@(posedge clk) disable iff (!rst_sn)
    oe_n |-> (!rvalid && rdata == '0));

  // R8: deselecting command turns the drivers off
  a_r8_dsel_quiet: assert property (@(posedge clk) disable iff (!rst_sn)
    (cmd_ok && !sel_ok) |=> !rvalid);

  // R11: no driving in the cycle after a write command
  a_r11_write_quiet: assert property (@(posedge clk) disable iff (!rst_sn)
    (cmd_ok && sel_ok && !wr_n) |=> !rvalid);

  // R1: a selected read drives unless output enable is off
  a_r1_read_drive: assert property (@(posedge clk) disable iff (!rst_sn)
    (cmd_ok && sel_ok && wr_n) |=> (oe_n || rvalid));

  // R7: a held edge leaves the read data untouched
  a_r7_hold_freeze: assert property (@(posedge clk) disable iff (!rst_sn)
    hold |=> (!$stable(oe_n) || $stable(rdata)));
endmodule

bind lwsram lwsram_chk #(.DW(WORD_W)) u_chk (
  .clk    (clk),
  .rst_sn (rst_sn),
  .hold   (hold),
  .en0_n  (en0_n),
  .en1    (en1),
  .en2_n  (en2_n),
  .wr_n   (wr_n),
  .adv    (adv),
  .oe_n   (oe_n),
  .rdata  (rdata),
  .rvalid (rvalid)
);

// File: tb/sim_lwsram.sv
module sim_lwsram;
  localparam int DEPTH = 64;
  localparam int AW    = 6;
  localparam int DW    = 18;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          hold, en0_n, en1, en2_n, wr_n, adv, ord_lin, oe_n;
  logic [1:0]    be_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic          rvalid;

  int n_run  = 0;
  int n_fail = 0;
  logic [DW-1:0] mdl [DEPTH];

  always #5 clk = ~clk;

  lwsram #(.DEPTH(DEPTH), .LANE_W(9), .LANES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .hold(hold), .en0_n(en0_n), .en1(en1), .en2_n(en2_n),
    .wr_n(wr_n), .be_n(be_n), .adv(adv), .ord_lin(ord_lin), .addr(addr),
    .wdata(wdata), .oe_n(oe_n), .rdata(rdata), .rvalid(rvalid)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic go();
    @(negedge clk);
  endtask

  task automatic idle();
    hold = 0; en0_n = 1; en1 = 1; en2_n = 0; wr_n = 1; adv = 0; be_n = 2'b00;
  endtask

  task automatic cmd_rd(input logic [AW-1:0] a);
    hold = 0; en0_n = 0; en1 = 1; en2_n = 0; wr_n = 1; adv = 0; addr = a;
  endtask

  task automatic cmd_wr(input logic [AW-1:0] a, input logic [1:0] ben);
    hold = 0; en0_n = 0; en1 = 1; en2_n = 0; wr_n = 0; adv = 0; addr = a; be_n = ben;
  endtask

  // advance with every ignored input driven to junk
  task automatic cmd_adv();
    hold = 0; adv = 1; addr = ~addr; en0_n = 1; en1 = 0; en2_n = 1; wr_n = ~wr_n;
    ord_lin = ~ord_lin;
  endtask

  task automatic upd(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [1:0] ben);
    if (!ben[0]) mdl[a][8:0]  = d[8:0];
    if (!ben[1]) mdl[a][17:9] = d[17:9];
  endtask

  task automatic wr_word(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [1:0] ben);
    cmd_wr(a, ben); go();
    idle(); be_n = ben; wdata = d; go();
    upd(a, d, ben);
    wdata = '0; be_n = 2'b00;
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input string req);
    cmd_rd(a); go();
    chk({req, " data"}, rdata, mdl[a]);
    chk({req, " valid"}, {17'd0, rvalid}, 18'd1);
  endtask

  task automatic t_reset();
    rst_n = 0; idle(); ord_lin = 0; oe_n = 0; addr = '0; wdata = '0;
    repeat (3) go();
    chk("R10 reset valid", {17'd0, rvalid}, 18'd0);
    rst_n = 1;
    repeat (3) go();
    chk("R10 after release valid", {17'd0, rvalid}, 18'd0);
    chk("R10 after release data", rdata, '0);
  endtask

  task automatic t_basic();
    wr_word(6'd3, 18'h12345, 2'b00);
    cmd_wr(6'd4, 2'b00); go();
    chk("R11 write not driving", {17'd0, rvalid}, 18'd0);
    idle(); wdata = 18'h0ABCD; go(); upd(6'd4, 18'h0ABCD, 2'b00);
    rd_chk(6'd3, "R1");
    rd_chk(6'd4, "R2");
  endtask

  task automatic t_turn();
    cmd_wr(6'd5, 2'b00); go();
    wdata = 18'h11111; cmd_rd(6'd5); go(); upd(6'd5, 18'h11111, 2'b00);
    chk("R3 forward read", rdata, 18'h11111);
    cmd_wr(6'd6, 2'b00); go();
    wdata = 18'h22222; cmd_rd(6'd3); go(); upd(6'd6, 18'h22222, 2'b00);
    chk("R3 read other during data", rdata, mdl[3]);
    cmd_rd(6'd6); go();
    chk("R3 read after commit", rdata, 18'h22222);
    cmd_wr(6'd7, 2'b00); go();
    wdata = 18'h33333; cmd_wr(6'd8, 2'b00); go(); upd(6'd7, 18'h33333, 2'b00);
    wdata = 18'h04444; cmd_rd(6'd7); go(); upd(6'd8, 18'h04444, 2'b00);
    chk("R3 write-write-read", rdata, 18'h33333);
    cmd_rd(6'd8); go();
    chk("R3 read just written", rdata, 18'h04444);
    idle(); go();
  endtask

  task automatic t_lanes();
    wr_word(6'd9, 18'h2AAAA, 2'b00);
    cmd_wr(6'd9, 2'b10); go();
    wdata = 18'h3FFFF; be_n = 2'b10; cmd_rd(6'd9); go(); upd(6'd9, 18'h3FFFF, 2'b10);
    chk("R4 lane0 merged forward", rdata, {9'h155, 9'h1FF});
    be_n = 2'b00; cmd_rd(6'd9); go();
    chk("R4 lane0 merged array", rdata, mdl[9]);
    wr_word(6'd9, 18'h00000, 2'b01);
    rd_chk(6'd9, "R4 lane1");
    wr_word(6'd9, 18'h15A5A, 2'b11);
    rd_chk(6'd9, "R4 no lanes");
  endtask

  task automatic t_burst();
    // interleaved write burst from 10: 10, 11, 8, 9
    ord_lin = 0; cmd_wr(6'd10, 2'b00); go();
    for (int i = 0; i < 3; i++) begin
      cmd_adv(); be_n = 2'b00; wdata = 18'h00100 + 18'(i); go();
      chk("R5 write burst not driving", {17'd0, rvalid}, 18'd0);
    end
    upd(6'd10, 18'h00100, 2'b00); upd(6'd11, 18'h00101, 2'b00);
    upd(6'd8, 18'h00102, 2'b00);  upd(6'd9, 18'h00103, 2'b00);
    wdata = 18'h00103; cmd_rd(6'd11); go();
    chk("R6 interleave second", rdata, 18'h00101);
    rd_chk(6'd8, "R6 interleave third");
    rd_chk(6'd9, "R6 interleave fourth");
    rd_chk(6'd10, "R6 interleave first");
    // linear read burst from 9: 9, 10, 11, 8
    ord_lin = 1; cmd_rd(6'd9); go();
    chk("R6 linear 0", rdata, mdl[9]);
    cmd_adv(); go(); chk("R5 linear 1", rdata, mdl[10]);
    cmd_adv(); go(); chk("R6 linear 2", rdata, mdl[11]);
    cmd_adv(); go(); chk("R6 linear wrap", rdata, mdl[8]);
    // interleaved read burst from 9: 9, 8, 11, 10
    ord_lin = 0; cmd_rd(6'd9); go();
    chk("R6 xor 0", rdata, mdl[9]);
    cmd_adv(); go(); chk("R6 xor 1", rdata, mdl[8]);
    cmd_adv(); go(); chk("R6 xor 2", rdata, mdl[11]);
    idle(); ord_lin = 0; go();
  endtask

  task automatic t_hold();
    cmd_wr(6'd12, 2'b00); go();
    hold = 1; wdata = 18'h3DEAD; go();
    hold = 1; wdata = 18'h0BEEF; go();
    chk("R7 held write not driving", {17'd0, rvalid}, 18'd0);
    wdata = 18'h07777; cmd_rd(6'd12); go(); upd(6'd12, 18'h07777, 2'b00);
    chk("R7 data taken after hold", rdata, 18'h07777);
    cmd_rd(6'd3); go();
    cmd_rd(6'd4); hold = 1; go();
    chk("R7 read held", rdata, mdl[3]);
    hold = 0; go();
    chk("R7 read after hold", rdata, mdl[4]);
    ord_lin = 1; cmd_rd(6'd8); go();
    cmd_adv(); hold = 1; go();
    chk("R7 burst held", rdata, mdl[8]);
    hold = 0; go();
    chk("R7 burst resumes", rdata, mdl[9]);
    idle(); ord_lin = 0; go();
  endtask

  task automatic t_dsel();
    cmd_rd(6'd3); en0_n = 1; go();
    chk("R8 en0_n high", {rdata[16:0], rvalid}, 18'd0);
    cmd_rd(6'd3); en1 = 0; go();
    chk("R8 en1 low", {rdata[16:0], rvalid}, 18'd0);
    cmd_rd(6'd3); en2_n = 1; go();
    chk("R8 en2_n high", {rdata[16:0], rvalid}, 18'd0);
    cmd_adv(); go();
    chk("R8 advance stays deselected", {17'd0, rvalid}, 18'd0);
    cmd_wr(6'd3, 2'b00); en1 = 0; go();
    idle(); wdata = 18'h3C3C3; go();
    idle(); go();
    rd_chk(6'd3, "R8 deselected write ignored");
  endtask

  task automatic t_oe();
    cmd_rd(6'd4); go();
    chk("R9 driving", {17'd0, rvalid}, 18'd1);
    oe_n = 1; #1;
    chk("R9 oe high valid", {17'd0, rvalid}, 18'd0);
    chk("R9 oe high data", rdata, '0);
    oe_n = 0; #1;
    chk("R9 oe low again", rdata, mdl[4]);
    idle(); go();
  endtask

  logic done = 1'b0;

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mdl[i] = '0;
    t_reset();
    t_basic();
    t_turn();
    t_lanes();
    t_burst();
    t_hold();
    t_dsel();
    t_oe();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule